// File: doc/BRIEF.md
# Limit-Event Buffer FIFO

This block is a first-in first-out queue for one transmit or receive channel. Its entries live in a window of a buffer that several channels can share. The window begins at a programmable base offset and has a power-of-two depth chosen by a size code. A size code of zero switches the queue off. A programmable fill-level threshold drives a single "standard" event, and that event can be set to watch either direction. In edge mode it fires only when the fill level moves across the threshold. In level mode it fires on every operation that leaves the level past the threshold.

Each event is delivered as a one-cycle pulse on one of several service-request lines. A small pointer picks the line for the standard event, and a second pointer picks the line for the error event. Pushes into a full queue and pops from an empty queue are dropped. Each such drop sets a sticky flag and pulses the error line. The threshold can be rewritten while the queue holds data. Changing the size code flushes the queue.

Top module: `lvl_fifo`

## Requirements
- R1: After reset, `level` is 0, `empty` is 1, `full` is 0, both sticky flags are 0 and `srq` is all zero.
- R2: A size code n from 1 to 6 gives a depth of 2^n entries. Codes 7 and above give 64 entries. `full` is 1 exactly when the queue is enabled and `level` equals the depth. A change of the size code empties the queue at the next clock edge.
- R3: With size code 0, `level` stays 0 and `empty` stays 1. Pushes and pops are ignored, and they set neither error flag.
- R4: Words leave the queue in the order they entered. `pop_data` always shows the oldest word without any delay. Word k of the queue is stored at buffer address (base + k) mod 64, so the window may wrap past the end of the buffer.
- R5: A lone push while full and a pop while empty change nothing in the queue. They set `ovf_flag` and `udf_flag` respectively, and both flags are sticky until reset. Each also pulses `srq[cfg_err_node]` in the cycle after the edge.
- R6: A push and a pop in the same cycle, with the queue neither full nor empty, leave `level` unchanged and raise no standard event.
- R7: Falling edge mode (`cfg_rise`=0, `cfg_every`=0): a lone pop taken while `level` equals `cfg_limit` pulses the selected line. No other pop does.
- R8: Rising edge mode (`cfg_rise`=1, `cfg_every`=0): a lone push taken while `level` equals `cfg_limit` pulses the selected line. No other push does.
- R9: Level mode (`cfg_every`=1). With `cfg_rise`=0, every lone pop that leaves `level` below `cfg_limit` pulses the line. With `cfg_rise`=1, every lone push that leaves `level` above `cfg_limit` pulses the line.
- R10: The event pulse appears on `srq` bit number `cfg_node` and lasts exactly the one cycle after the triggering edge. No other bit of `srq` rises unless an error event falls in the same cycle.
- R11: Rewriting `cfg_limit` while the queue holds words keeps both `level` and the stored data. The new threshold governs the next operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base | input | 6 | Window start in the shared buffer |
| cfg_size | input | 3 | Size code: 0 off, n gives 2^n entries |
| cfg_limit | input | 7 | Fill-level threshold |
| cfg_rise | input | 1 | 1: watch pushes upward, 0: watch pops downward |
| cfg_every | input | 1 | 1: level mode, 0: edge-only mode |
| cfg_node | input | 3 | Output line for the standard event |
| cfg_err_node | input | 3 | Output line for the error event |
| push | input | 1 | Write request |
| push_data | input | 8 | Word to write |
| pop | input | 1 | Read request |
| pop_data | output | 8 | Oldest stored word |
| level | output | 7 | Number of stored words |
| full | output | 1 | Level equals depth |
| empty | output | 1 | Level is zero |
| ovf_flag | output | 1 | Sticky: push refused while full |
| udf_flag | output | 1 | Sticky: pop refused while empty |
| srq | output | 8 | One-cycle service-request pulses |

## Verification
Outputs arrive with different delays. `pop_data` is combinational and is due in the same cycle as the pop request, so the bench compares it half a step after driving inputs and before the edge. `level`, `full`, `empty`, the sticky flags and `srq` are all updated by the one clock edge that samples the request, so the bench reads them 1 ns after that edge. A size change needs one further edge to flush, and the bench waits for that edge before it expects `level` to read 0. The expected event pulses come from an arithmetic model of the queue kept in the bench. That model is swept across every threshold for depths 2, 4 and 8, in all four event modes.

// File: rtl/lvl_fifo.sv
module lvl_fifo #(
  parameter int DW        = 8,
  parameter int BUF_DEPTH = 64,
  parameter int NODES     = 8,
  parameter int SZW       = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [$clog2(BUF_DEPTH)-1:0]     cfg_base,
  input  logic [SZW-1:0]                   cfg_size,
  input  logic [$clog2(BUF_DEPTH):0]       cfg_limit,
  input  logic                             cfg_rise,
  input  logic                             cfg_every,
  input  logic [$clog2(NODES)-1:0]         cfg_node,
  input  logic [$clog2(NODES)-1:0]         cfg_err_node,
  input  logic                             push,
  input  logic [DW-1:0]                    push_data,
  input  logic                             pop,
  output logic [DW-1:0]                    pop_data,
  output logic [$clog2(BUF_DEPTH):0]       level,
  output logic                             full,
  output logic                             empty,
  output logic                             ovf_flag,
  output logic                             udf_flag,
  output logic [NODES-1:0]                 srq
);
  localparam int AW = $clog2(BUF_DEPTH);
  localparam logic [SZW-1:0] MAXC = SZW'(AW);

  logic [DW-1:0]  mem [BUF_DEPTH];
  logic [SZW-1:0] size_q;
  logic [AW-1:0]  wr_off, rd_off;
  logic [AW:0]    level_q;
  logic [NODES-1:0] srq_d;

  logic [SZW-1:0] sz_eff;
  logic [AW:0]    depth;
  logic [AW-1:0]  mask;
  logic en, act, full_i, empty_i, wok, rok, ovf, udf, lone_w, lone_r;
  logic hit_rise, hit_fall, std_evt;

  assign sz_eff  = (cfg_size > MAXC) ? MAXC : cfg_size;
  assign depth   = {{AW{1'b0}}, 1'b1} << sz_eff;
  assign mask    = depth[AW-1:0] - 1'b1;
  assign en      = cfg_size != '0;
  assign act     = en && (cfg_size == size_q);
  assign full_i  = en && (level_q == depth);
  assign empty_i = level_q == '0;

  assign wok    = push && act && !full_i;
  assign rok    = pop  && act && !empty_i;
  assign ovf    = push && act && full_i;
  assign udf    = pop  && act && empty_i;
  assign lone_w = wok && !rok;
  assign lone_r = rok && !wok;

  assign hit_rise = lone_w && (cfg_every ? (level_q >= cfg_limit) : (level_q == cfg_limit));
  assign hit_fall = lone_r && (cfg_every ? (level_q <= cfg_limit) : (level_q == cfg_limit));
  assign std_evt  = cfg_rise ? hit_rise : hit_fall;

  always_comb begin
    srq_d = '0;
    if (std_evt)    srq_d[cfg_node]     = 1'b1;
    if (ovf || udf) srq_d[cfg_err_node] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q   <= '0;
      wr_off   <= '0;
      rd_off   <= '0;
      level_q  <= '0;
      ovf_flag <= 1'b0;
      udf_flag <= 1'b0;
      srq      <= '0;
    end else begin
      size_q <= cfg_size;
      srq    <= srq_d;
      if (ovf) ovf_flag <= 1'b1;
      if (udf) udf_flag <= 1'b1;
      if (!act) begin
        wr_off  <= '0;
        rd_off  <= '0;
        level_q <= '0;
      end else begin
        if (wok) wr_off <= (wr_off + 1'b1) & mask;
        if (rok) rd_off <= (rd_off + 1'b1) & mask;
        if (lone_w)      level_q <= level_q + 1'b1;
        else if (lone_r) level_q <= level_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wok) mem[cfg_base + wr_off] <= push_data;
  end

  assign pop_data = mem[cfg_base + rd_off];
  assign level    = level_q;
  assign full     = full_i;
  assign empty    = empty_i;
endmodule

module lvl_fifo_chk #(
  parameter int AW    = 6,
  parameter int NODES = 8,
  parameter int SZW   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SZW-1:0]   cfg_size,
  input logic             push,
  input logic             pop,
  input logic [AW:0]      level,
  input logic             full,
  input logic             empty,
  input logic             ovf_flag,
  input logic             udf_flag,
  input logic [NODES-1:0] srq
);
  logic [SZW-1:0] szc;
  logic [AW:0]    cap;
  assign szc = (cfg_size > SZW'(AW)) ? SZW'(AW) : cfg_size;
  assign cap = {{AW{1'b0}}, 1'b1} << szc;

  p_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_size == '0 && $past(cfg_size) == '0) |-> (level == '0 && empty && !full));
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(cfg_size) |-> level <= cap);
  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_size) == $past(cfg_size, 2)) |->
      (level == $past(level) || level == $past(level) + 1'b1 || level + 1'b1 == $past(level)));
  p_full_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> ovf_flag);
  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ovf_flag) |-> ovf_flag);
  p_udf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(udf_flag) |-> udf_flag);
  p_srq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (srq != '0) |-> $past(push || pop));
  p_srq_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(srq) <= 2);
endmodule

bind lvl_fifo lvl_fifo_chk #(.AW(AW), .NODES(NODES), .SZW(SZW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .push(push), .pop(pop),
  .level(level), .full(full), .empty(empty), .ovf_flag(ovf_flag),
  .udf_flag(udf_flag), .srq(srq)
);

// File: tb/lvl_fifo_bench.sv
`timescale 1ns/1ps
module lvl_fifo_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] cfg_base = '0;
  logic [2:0] cfg_size = '0;
  logic [6:0] cfg_limit = '0;
  logic cfg_rise = 1'b0, cfg_every = 1'b0;
  logic [2:0] cfg_node = '0, cfg_err_node = 3'd7;
  logic push = 1'b0, pop = 1'b0;
  logic [7:0] push_data = '0;
  logic [7:0] pop_data;
  logic [6:0] level;
  logic full, empty, ovf_flag, udf_flag;
  logic [7:0] srq;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] mq[$];
  int dep = 0;
  bit en = 0;

  always #2.5 clk = ~clk;

  lvl_fifo u_lvl_fifo (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic configure(input int sz, input int base, input int lim, input bit r,
                           input bit ev, input int nd);
    @(negedge clk); push = 0; pop = 0; cfg_size = 0;
    @(posedge clk);
    @(negedge clk);
    cfg_size = 3'(sz); cfg_base = 6'(base); cfg_limit = 7'(lim);
    cfg_rise = r; cfg_every = ev; cfg_node = 3'(nd);
    @(posedge clk); #1;
    mq.delete();
    en  = sz != 0;
    dep = (sz == 0) ? 0 : (1 << ((sz > 6) ? 6 : sz));
    chk(level == 0 && empty, "R2 flush on size change", int'(level), 0);
  endtask

  task automatic step(input bit p, input bit q, input logic [7:0] d, input string tag);
    int lvl;
    bit fu, em, wok, rok, ovf, udf, sv;
    logic [7:0] es;
    lvl = mq.size();
    fu = en && (lvl == dep); em = lvl == 0;
    wok = p && en && !fu; rok = q && en && !em;
    ovf = p && en && fu;  udf = q && en && em;
    if (cfg_rise) sv = wok && !rok && (cfg_every ? lvl >= int'(cfg_limit) : lvl == int'(cfg_limit));
    else          sv = rok && !wok && (cfg_every ? lvl <= int'(cfg_limit) : lvl == int'(cfg_limit));
    es = '0;
    if (sv) es[cfg_node] = 1'b1;
    if (ovf || udf) es[cfg_err_node] = 1'b1;
    @(negedge clk); push = p; pop = q; push_data = d;
    #0.5;
    if (rok) chk(pop_data == mq[0], "R4 order", int'(pop_data), int'(mq[0]));
    @(posedge clk); #1;
    push = 0; pop = 0;
    if (rok) void'(mq.pop_front());
    if (wok) mq.push_back(d);
    chk(int'(level) == mq.size(), {tag, " level"}, int'(level), mq.size());
    chk(full == (en && mq.size() == dep), "R2 full", int'(full), int'(en && mq.size() == dep));
    chk(empty == (mq.size() == 0), "R2 empty", int'(empty), int'(mq.size() == 0));
    chk(srq == es, {tag, " R10 srq"}, int'(srq), int'(es));
  endtask

  initial begin
    #750000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(level == 0 && empty && !full, "R1 reset level", int'(level), 0);
    chk(!ovf_flag && !udf_flag && srq == 0, "R1 reset flags", int'({ovf_flag, udf_flag}), 0);
    @(negedge clk); rst_n = 1;

    configure(0, 0, 0, 1, 1, 3);
    step(1, 0, 8'h11, "R3");
    step(1, 0, 8'h12, "R3");
    step(0, 1, 8'h00, "R3");
    chk(!ovf_flag && !udf_flag, "R3 no error when off", int'({ovf_flag, udf_flag}), 0);

    for (int sz = 1; sz <= 3; sz++)
      for (int r = 0; r < 2; r++)
        for (int ev = 0; ev < 2; ev++)
          for (int l = 0; l <= (1 << sz); l++) begin
            string tag;
            tag = ev ? "R9" : (r ? "R8" : "R7");
            configure(sz, 60 + sz, l, r[0], ev[0], l % 7);
            for (int k = 0; k <= (1 << sz); k++) step(1, 0, 8'(k * 37 + l), tag);
            for (int k = 0; k <= (1 << sz); k++) step(0, 1, 8'h00, tag);
          end
    chk(ovf_flag == 1, "R5 overflow sticky", int'(ovf_flag), 1);
    chk(udf_flag == 1, "R5 underflow sticky", int'(udf_flag), 1);

    configure(7, 40, 64, 1, 0, 5);
    for (int k = 0; k < 64; k++) step(1, 0, 8'(k ^ 8'h5A), "R2");
    chk(full == 1 && level == 64, "R2 depth 64", int'(level), 64);
    step(1, 0, 8'hEE, "R5");
    for (int k = 0; k < 64; k++) step(0, 1, 8'h00, "R4");

    configure(3, 10, 0, 1, 1, 2);
    for (int k = 0; k < 3; k++) step(1, 0, 8'(k + 100), "R9");
    for (int k = 0; k < 5; k++) step(1, 1, 8'(k + 200), "R6");
    chk(level == 3, "R6 level kept", int'(level), 3);
    for (int k = 0; k < 3; k++) step(0, 1, 8'h00, "R6");

    configure(3, 0, 2, 1, 0, 4);
    step(1, 0, 8'hA1, "R11");
    step(1, 0, 8'hA2, "R11");
    @(negedge clk); cfg_limit = 7'd5;
    @(posedge clk); #1;
    chk(level == 2, "R11 level after limit change", int'(level), 2);
    for (int k = 0; k < 4; k++) step(1, 0, 8'(8'hB0 + k), "R11");
    chk(level == 6, "R11 level", int'(level), 6);
    for (int k = 0; k < 6; k++) step(0, 1, 8'h00, "R11");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule